// File: doc/BRIEF.md
# DMA Channel Control and Condition Unit

This block holds the 16-bit control and status word of one DMA channel, together with three condition selectors: interrupt, branch and wait. A command sequencer reads the run, pause and flush bits and a one-cycle wake pulse from it. The sequencer also uses three condition signals. Each condition is true when the masked device-status byte equals a programmed pattern. Descriptor fetch and data movement are handled elsewhere.

Software changes the control word with a masked write. One 32-bit word carries a 16-bit mask and a 16-bit value, and only the bits selected by the mask change. Hardware can update the eight device-status bits with its own mask and value, and it can flag that a branch was taken. The dead and active bits follow the sequencer's inputs directly and cannot be written by software.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, the run, pause, flush, wake, branch-taken and device-status bits read 0. All three selectors hold mask 0 and value 0, so all three conditions read 1.
- R2: A software write (`sw_wr_en`) carries the mask in `sw_wr_word[31:16]` and the value in `sw_wr_word[15:0]`. On the next cycle every writable bit whose mask bit is 1 takes the value bit, and every other bit is unchanged. Mask 0x0003 with value 0 clears bits 1:0 only. The writable bits are run (bit 15), pause (14), flush (13), branch-taken (8) and device status (7:0).
- R3: Bit 11 (dead) always reads `dead_in` and bit 10 (active) always reads `active_in`. Software writes to these bits are ignored. Bit 9 always reads 0.
- R4: A `hw_branch_set` pulse makes bit 8 read 1 from the next cycle on. The bit stays set until software clears it with a masked write.
- R5: A software write with mask bit 12 and value bit 12 both set drives `wake_pulse` high for exactly the next cycle, and bit 12 reads 1 in that cycle only. A write of 0 to bit 12 gives no pulse.
- R6: A hardware device update (`hw_dev_en`) sets device-status bit i to `hw_dev_val[i]` wherever `hw_dev_mask[i]` is 1, on the next cycle. The other bits keep their value.
- R7: When a software write and a hardware device update fall in the same cycle, the software value wins for the bits in its mask. The hardware update applies to the remaining bits.
- R8: A selector write (`sel_wr_en`) replaces the selector chosen by `sel_wr_idx`: 0 interrupt, 1 branch, 2 wait. `sel_wr_data[15:8]` is the mask and `[7:0]` is the value. Index 3 is ignored. `sel_rd_data` shows the selector chosen by `sel_rd_idx` in the same layout, and reads 0 for index 3.
- R9: Each condition output is 1 exactly when (device status AND selector mask) equals the selector value, evaluated from the current register contents in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Software masked write strobe |
| sw_wr_word | input | 32 | Mask in [31:16], value in [15:0] |
| hw_dev_en | input | 1 | Hardware device-status update strobe |
| hw_dev_mask | input | 8 | Hardware update mask |
| hw_dev_val | input | 8 | Hardware update value |
| hw_branch_set | input | 1 | Branch-taken flag from the sequencer |
| dead_in | input | 1 | Channel dead state |
| active_in | input | 1 | Channel active state |
| sel_wr_en | input | 1 | Selector write strobe |
| sel_wr_idx | input | 2 | Selector to write |
| sel_wr_data | input | 16 | Selector mask [15:8] and value [7:0] |
| sel_rd_idx | input | 2 | Selector to read |
| ctl_rd | output | 16 | Control/status word |
| sel_rd_data | output | 16 | Selected selector contents |
| run | output | 1 | Run bit |
| pause | output | 1 | Pause bit |
| flush | output | 1 | Flush bit |
| wake_pulse | output | 1 | One-cycle wake request |
| cond_int | output | 1 | Interrupt condition true |
| cond_branch | output | 1 | Branch condition true |
| cond_wait | output | 1 | Wait condition true |

## Verification
The embedded properties check four things on every cycle. A wake pulse only follows a wake write and then drops. Masked software bits land exactly, even against a simultaneous hardware update, while unmasked device bits hold. A branch flag is never lost unless software masks bit 8. A write to selector index 3 leaves all selectors untouched. The bench runs a long random mix of writes, hardware updates and selector programming against a reference model, plus directed cases: the clear-two-bits example, a collision on shared bits, and a write to the read-only bits. These are the only way to show that the condition outputs track every combination of status, mask and value.

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_wr_en,
  input  logic [31:0] sw_wr_word,
  input  logic        hw_dev_en,
  input  logic [7:0]  hw_dev_mask,
  input  logic [7:0]  hw_dev_val,
  input  logic        hw_branch_set,
  input  logic        dead_in,
  input  logic        active_in,
  input  logic        sel_wr_en,
  input  logic [1:0]  sel_wr_idx,
  input  logic [15:0] sel_wr_data,
  input  logic [1:0]  sel_rd_idx,
  output logic [15:0] ctl_rd,
  output logic [15:0] sel_rd_data,
  output logic        run,
  output logic        pause,
  output logic        flush,
  output logic        wake_pulse,
  output logic        cond_int,
  output logic        cond_branch,
  output logic        cond_wait
);

  logic        run_q, pause_q, flush_q, wake_q, brt_q;
  logic [7:0]  dev_q;
  logic [15:0] sel_q [3];

  logic [15:0] wm, wv;
  logic [7:0]  dev_hw, dev_d;

  assign wm = sw_wr_en ? sw_wr_word[31:16] : 16'h0;
  assign wv = sw_wr_word[15:0];

  assign dev_hw = hw_dev_en ? ((dev_q & ~hw_dev_mask) | (hw_dev_val & hw_dev_mask)) : dev_q;
  assign dev_d  = (dev_hw & ~wm[7:0]) | (wv[7:0] & wm[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pause_q <= 1'b0;
      flush_q <= 1'b0;
      wake_q  <= 1'b0;
      brt_q   <= 1'b0;
      dev_q   <= 8'h0;
    end else begin
      if (wm[15]) run_q   <= wv[15];
      if (wm[14]) pause_q <= wv[14];
      if (wm[13]) flush_q <= wv[13];
      wake_q <= wm[12] & wv[12];
      brt_q  <= wm[8] ? wv[8] : (brt_q | hw_branch_set);
      dev_q  <= dev_d;
    end
  end

  for (genvar i = 0; i < 3; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[i] <= 16'h0;
      else if (sel_wr_en && sel_wr_idx == 2'(i))
        sel_q[i] <= sel_wr_data;
    end
  end

  assign sel_rd_data = (sel_rd_idx == 2'd3) ? 16'h0 : sel_q[sel_rd_idx];

  assign ctl_rd = {run_q, pause_q, flush_q, wake_q, dead_in, active_in, 1'b0, brt_q, dev_q};
  assign run        = run_q;
  assign pause      = pause_q;
  assign flush      = flush_q;
  assign wake_pulse = wake_q;

  assign cond_int    = (dev_q & sel_q[0][15:8]) == sel_q[0][7:0];
  assign cond_branch = (dev_q & sel_q[1][15:8]) == sel_q[1][7:0];
  assign cond_wait   = (dev_q & sel_q[2][15:8]) == sel_q[2][7:0];

  p_wake_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sw_wr_en && sw_wr_word[28] && sw_wr_word[12]));

  p_wake_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && !(sw_wr_en && sw_wr_word[28] && sw_wr_word[12])) |=> !wake_pulse);

  p_sw_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> ((ctl_rd[7:0] & $past(sw_wr_word[23:16])) == ($past(sw_wr_word[7:0]) & $past(sw_wr_word[23:16]))));

  p_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_en && !hw_dev_en) |=> (((ctl_rd[7:0] ^ $past(ctl_rd[7:0])) & ~$past(sw_wr_word[23:16])) == 8'h0));

  p_branch_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_branch_set && !(sw_wr_en && sw_wr_word[24])) |=> ctl_rd[8]);

  p_sel_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_wr_en && sel_wr_idx == 2'd3) |=> ($stable(sel_q[0]) && $stable(sel_q[1]) && $stable(sel_q[2])));

endmodule

// File: tb/sim_dma_chan_ctl.sv
module sim_dma_chan_ctl;
  logic        clk = 0, rst_n = 0;
  logic        sw_wr_en = 0;
  logic [31:0] sw_wr_word = 0;
  logic        hw_dev_en = 0;
  logic [7:0]  hw_dev_mask = 0, hw_dev_val = 0;
  logic        hw_branch_set = 0, dead_in = 0, active_in = 0;
  logic        sel_wr_en = 0;
  logic [1:0]  sel_wr_idx = 0, sel_rd_idx = 0;
  logic [15:0] sel_wr_data = 0;
  logic [15:0] ctl_rd, sel_rd_data;
  logic        run, pause, flush, wake_pulse, cond_int, cond_branch, cond_wait;

  int compared = 0, mismatched = 0;

  logic [15:0] m_ctl;
  logic [15:0] m_sel [3];

  dma_chan_ctl u0 (.*);

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic cond(input logic [7:0] dev, input logic [15:0] s);
    return (dev & s[15:8]) == s[7:0];
  endfunction

  function automatic logic [15:0] next_ctl(input logic [15:0] c);
    logic [15:0] n, m, v;
    n = c;
    n[12] = 1'b0;
    if (hw_dev_en) n[7:0] = (n[7:0] & ~hw_dev_mask) | (hw_dev_val & hw_dev_mask);
    if (hw_branch_set) n[8] = 1'b1;
    m = sw_wr_en ? sw_wr_word[31:16] : 16'h0;
    v = sw_wr_word[15:0];
    n = (n & ~(m & 16'hE1FF)) | (v & m & 16'hE1FF);
    n[12] = m[12] & v[12];
    return n;
  endfunction

  task automatic tick();
    logic [15:0] n;
    n = next_ctl(m_ctl);
    if (sel_wr_en && sel_wr_idx != 2'd3) m_sel[sel_wr_idx] = sel_wr_data;
    @(posedge clk);
    #1;
    m_ctl = n;
  endtask

  task automatic idle();
    sw_wr_en = 0; hw_dev_en = 0; hw_branch_set = 0; sel_wr_en = 0;
  endtask

  task automatic check_all(input string tag);
    logic [15:0] exp;
    exp = m_ctl;
    exp[11] = dead_in;
    exp[10] = active_in;
    exp[9]  = 1'b0;
    chk({tag, " R2/R3 ctl_rd"}, 32'(ctl_rd), 32'(exp));
    chk({tag, " R5 wake_pulse"}, 32'(wake_pulse), 32'(exp[12]));
    chk({tag, " R2 run/pause/flush"}, 32'({run, pause, flush}), 32'(exp[15:13]));
    chk({tag, " R9 cond"}, 32'({cond_int, cond_branch, cond_wait}),
        32'({cond(exp[7:0], m_sel[0]), cond(exp[7:0], m_sel[1]), cond(exp[7:0], m_sel[2])}));
    chk({tag, " R8 sel_rd"}, 32'(sel_rd_data), 32'((sel_rd_idx == 2'd3) ? 16'h0 : m_sel[sel_rd_idx]));
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ctl = 0;
    for (int i = 0; i < 3; i++) m_sel[i] = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    #1;
    check_all("R1 reset");
    chk("R1 conds after reset", 32'({cond_int, cond_branch, cond_wait}), 32'h7);

    sw_wr_en = 1; sw_wr_word = 32'h00FF_00A7; tick(); idle(); check_all("R2 set dev");
    chk("R2 dev A7", 32'(ctl_rd[7:0]), 32'hA7);
    sw_wr_en = 1; sw_wr_word = 32'h0003_0000; tick(); idle(); check_all("R2 clear two");
    chk("R2 mask 03 clears low bits", 32'(ctl_rd[7:0]), 32'hA4);

    sw_wr_en = 1; sw_wr_word = 32'h0E00_0E00; dead_in = 0; active_in = 1; tick(); idle();
    check_all("R3 ro write");
    chk("R3 dead/active/bit9", 32'(ctl_rd[11:9]), 32'b010);

    sw_wr_en = 1; sw_wr_word = 32'h1000_1000; tick(); idle();
    chk("R5 wake high", 32'(wake_pulse), 32'h1);
    chk("R5 bit12 high", 32'(ctl_rd[12]), 32'h1);
    tick();
    chk("R5 wake dropped", 32'({wake_pulse, ctl_rd[12]}), 32'h0);
    sw_wr_en = 1; sw_wr_word = 32'h1000_0000; tick(); idle();
    chk("R5 wake zero no pulse", 32'(wake_pulse), 32'h0);

    hw_branch_set = 1; tick(); idle(); tick();
    chk("R4 branch held", 32'(ctl_rd[8]), 32'h1);
    sw_wr_en = 1; sw_wr_word = 32'h0100_0000; hw_branch_set = 1; tick(); idle();
    chk("R4 sw clear wins", 32'(ctl_rd[8]), 32'h0);

    hw_dev_en = 1; hw_dev_mask = 8'hF0; hw_dev_val = 8'h5A; tick(); idle();
    chk("R6 hw update", 32'(ctl_rd[7:0]), 32'h54);
    hw_dev_en = 1; hw_dev_mask = 8'hFF; hw_dev_val = 8'hFF;
    sw_wr_en = 1; sw_wr_word = 32'h000F_0003; tick(); idle();
    chk("R7 collision", 32'(ctl_rd[7:0]), 32'hF3);

    sel_wr_en = 1; sel_wr_idx = 1; sel_wr_data = 16'h0F03; tick(); idle();
    sel_rd_idx = 1; #1;
    chk("R8 branch sel read", 32'(sel_rd_data), 32'h0F03);
    chk("R9 branch cond true", 32'(cond_branch), 32'h1);
    sel_wr_en = 1; sel_wr_idx = 3; sel_wr_data = 16'hFFFF; tick(); idle();
    for (int k = 0; k < 4; k++) begin
      sel_rd_idx = 2'(k); #1;
      chk("R8 idx3 ignored", 32'(sel_rd_data), 32'((k == 3) ? 16'h0 : m_sel[k]));
    end
    check_all("directed end");

    for (int n = 0; n < 3000; n++) begin
      sw_wr_en      = ($urandom % 3) == 0;
      sw_wr_word    = $urandom;
      hw_dev_en     = ($urandom % 3) == 0;
      hw_dev_mask   = 8'($urandom);
      hw_dev_val    = 8'($urandom);
      hw_branch_set = ($urandom % 5) == 0;
      sel_wr_en     = ($urandom % 4) == 0;
      sel_wr_idx    = 2'($urandom);
      sel_wr_data   = ($urandom % 2) ? 16'($urandom) : {8'($urandom), 8'h0};
      tick();
      dead_in    = 1'($urandom);
      active_in  = 1'($urandom);
      sel_rd_idx = 2'($urandom);
      #1;
      check_all("random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule